// File: doc/BRIEF.md
# Control Setup Packet Readout

This block holds an eight-byte control setup packet that the device's automatic request handling has passed on, and lets an external master fetch it through a register port. When a new packet is loaded, the block raises an interrupt. The master reads one fixed register address over and over, and each read returns the next byte of the packet. A write of a non-zero value to that same address tells the device to stall the request.

The block also decodes two fields of the packet for the data-phase logic. The transfer direction comes from the top bit of the first byte. The requested data length is formed from the last two bytes. Both stay fixed until the next packet arrives.

Top module: `setup_pkt_port`

## Requirements
- R1: After reset, `rd_data`, `setup_irq`, `stall`, `dir_in` and `wlength` are all zero.
- R2: A cycle with `setup_vld` high raises `setup_irq` on the next cycle. `setup_irq` stays high until a read of the setup register (address 0x32) or a non-zero write to it.
- R3: Successive reads of address 0x32 return packet bytes 0 through 7 in order. Byte k sits in `setup_bytes[8k+7:8k]`, and each byte appears on `rd_data` in the cycle after its read strobe.
- R4: Reads of address 0x32 after the eighth byte return 0x00, and the sequence does not wrap.
- R5: A write of a non-zero value to address 0x32 sets `stall` on the next cycle, at any point in the readout. `stall` stays set until the next packet.
- R6: A write of zero to address 0x32, or any write to another address, leaves `stall`, `setup_irq` and the read sequence unchanged.
- R7: A new packet resets the read sequence to byte 0 and clears `stall`. Read or write strobes in the same cycle as `setup_vld` are ignored.
- R8: `dir_in` equals bit 7 of byte 0 of the last packet: 1 means IN (device to host) and 0 means OUT.
- R9: `wlength` equals byte 7 × 256 + byte 6 of the last packet, and it holds until the next packet.
- R10: A read of any address other than 0x32 returns 0x00 on `rd_data` and does not advance the read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_vld | input | 1 | Loads a new packet from `setup_bytes` |
| setup_bytes | input | 64 | Packet bytes, byte 0 in the low bits |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| setup_irq | output | 1 | Packet awaiting master handling |
| stall | output | 1 | Master requested a stall |
| dir_in | output | 1 | Data-phase direction, 1 = IN |
| wlength | output | 16 | Requested data-phase length |

## Verification
The readout is tried with full runs of ten reads, which show both the byte order and that the sequence does not wrap after the eighth byte. It is also tried with reads to other addresses mixed in, which show that only the setup address advances the sequence. Stall commands are issued before any read, in the middle of a readout, and as zero-valued and wrong-address writes, which separates real stalls from writes that must be ignored. New packets arrive in the middle of a readout and together with a read and a write strobe, which shows that the sequence is reset, the stall is cleared and the strobes in that cycle are ignored. Packets with each direction bit and different length bytes show that the direction and length fields come from the right bits.

// File: rtl/setup_pkt_port.sv
module setup_pkt_port #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] SETUP_ADDR = 8'h32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  setup_vld,
  input  logic [8*DATA_W-1:0]   setup_bytes,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  setup_irq,
  output logic                  stall,
  output logic                  dir_in,
  output logic [2*DATA_W-1:0]   wlength
);
  localparam int NBYTES = 8;
  localparam int PTR_W  = $clog2(NBYTES + 1);
  localparam int SEL_W  = $clog2(NBYTES);

  logic [8*DATA_W-1:0] pkt_q;
  logic [PTR_W-1:0]    ptr_q;
  logic                hit_rd, hit_wr, stall_cmd, done;
  logic [DATA_W-1:0]   cur_byte;

  assign hit_rd    = rd_en && reg_addr == SETUP_ADDR && !setup_vld;
  assign hit_wr    = wr_en && reg_addr == SETUP_ADDR && !setup_vld;
  assign stall_cmd = hit_wr && wr_data != '0;
  assign done      = ptr_q == PTR_W'(NBYTES);
  assign cur_byte  = done ? '0 : pkt_q[ptr_q[SEL_W-1:0]*DATA_W +: DATA_W];

  assign dir_in  = pkt_q[DATA_W-1];
  assign wlength = {pkt_q[7*DATA_W +: DATA_W], pkt_q[6*DATA_W +: DATA_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_q     <= '0;
      ptr_q     <= '0;
      rd_data   <= '0;
      setup_irq <= 1'b0;
      stall     <= 1'b0;
    end else if (setup_vld) begin
      pkt_q     <= setup_bytes;
      ptr_q     <= '0;
      setup_irq <= 1'b1;
      stall     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= hit_rd ? cur_byte : '0;
      if (hit_rd && !done) ptr_q <= ptr_q + 1'b1;
      if (hit_rd || stall_cmd) setup_irq <= 1'b0;
      if (stall_cmd) stall <= 1'b1;
    end
  end

  // R2
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_irq) |-> $past(setup_vld));
  // R5
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(wr_en && reg_addr == SETUP_ADDR && wr_data != '0));
  // R7
  stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_vld |=> !stall && setup_irq);
  // R4
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(NBYTES));
  // R9
  wlen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_vld |=> $stable(wlength) && $stable(dir_in));
  // R10
  other_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && reg_addr != SETUP_ADDR && !setup_vld |=> rd_data == '0 && $stable(ptr_q));
endmodule

// File: tb/setup_pkt_port_tb.sv
module setup_pkt_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_vld = 1'b0;
  logic [63:0] setup_bytes = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  reg_addr = '0, wr_data = '0;
  logic [7:0]  rd_data;
  logic        setup_irq, stall, dir_in;
  logic [15:0] wlength;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  setup_pkt_port dut_i (
    .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .setup_bytes(setup_bytes),
    .rd_en(rd_en), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .setup_irq(setup_irq), .stall(stall), .dir_in(dir_in),
    .wlength(wlength));

  byte unsigned m_pkt[8];
  int          m_idx = 0;
  logic [7:0]  m_rd = 0;
  bit          m_irq = 0, m_stall = 0, m_dir = 0;
  int          m_wlen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pkt[i]) m_pkt[i] = 0;
      m_idx = 0; m_rd = 0; m_irq = 0; m_stall = 0; m_dir = 0; m_wlen = 0;
    end else if (setup_vld) begin
      for (int i = 0; i < 8; i++) m_pkt[i] = setup_bytes[8*i +: 8];
      m_idx = 0; m_irq = 1; m_stall = 0;
      m_dir = m_pkt[0][7];
      m_wlen = m_pkt[7] * 256 + m_pkt[6];
    end else begin
      if (rd_en) begin
        if (reg_addr == 8'h32) begin
          m_rd = (m_idx < 8) ? m_pkt[m_idx] : 8'h00;
          if (m_idx < 8) m_idx++;
          m_irq = 0;
        end else m_rd = 8'h00;
      end
      if (wr_en && reg_addr == 8'h32 && wr_data != 0) begin
        m_stall = 1; m_irq = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R3/R4/R10 rd_data", rd_data, m_rd);
    chk("R2 setup_irq", setup_irq, m_irq);
    chk("R5/R6/R7 stall", stall, m_stall);
    chk("R8 dir_in", dir_in, m_dir);
    chk("R9 wlength", wlength, m_wlen);
  end

  task automatic idle();
    @(posedge clk); #1;
    setup_vld = 0; rd_en = 0; wr_en = 0;
  endtask

  task automatic load(input logic [63:0] b);
    setup_vld = 1; setup_bytes = b; idle();
  endtask

  task automatic rd(input logic [7:0] a);
    rd_en = 1; reg_addr = a; idle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; reg_addr = a; wr_data = d; idle();
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values checked by the negedge compare
    chk("R1 rd_data", rd_data, 0);
    chk("R1 stall", stall, 0);
    rst_n = 1;
    idle();
    // R3 R4 R8 R9: IN packet, full readout past the end
    load(64'h0140_0000_0006_80C1);
    for (int i = 0; i < 10; i++) rd(8'h32);
    // R10: other address read mid-sequence
    load(64'h0012_0000_0100_0621);
    rd(8'h32); rd(8'h31); rd(8'h32); rd(8'h00); rd(8'h32);
    // R6: zero and wrong-address writes
    wr(8'h32, 8'h00); wr(8'h33, 8'h5A);
    rd(8'h32);
    // R5: stall mid-readout, reads continue
    wr(8'h32, 8'h01);
    rd(8'h32); rd(8'h32); wr(8'h32, 8'hFF);
    // R7: new packet with strobes in the same cycle
    setup_vld = 1; setup_bytes = 64'hFFFF_1234_5678_9A3C;
    rd_en = 1; wr_en = 1; reg_addr = 8'h32; wr_data = 8'h7;
    idle();
    chk("R7 stall cleared", stall, 0);
    rd(8'h32); rd(8'h32);
    // R5: stall before any read
    load(64'h0000_0000_0000_0000);
    wr(8'h32, 8'h80);
    for (int i = 0; i < 9; i++) rd(8'h32);
    // R8: OUT packet then back-to-back packets
    load(64'h0102_0304_0506_0708);
    load(64'hA5A5_0000_0000_00FF);
    for (int i = 0; i < 4; i++) begin
      rd(8'h32); wr(8'h10, 8'h1); rd(8'h20);
    end
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule